// File: doc/BRIEF.md
# Dual PWM and Toggle Timer

This block is a pair of 8-bit up-counters that can be combined into one 16-bit counter. It drives two registered output pins: a low-half pin and a high-half pin. A two-bit mode input selects one of four uses:

- two separate toggle timers;
- two separate PWM generators;
- one cascaded 16-bit toggle timer, whose low byte also toggles its own pin;
- one cascaded 16-bit toggle timer whose low byte generates PWM at the same time.

Each half has a period register and a compare register. The counters advance only on cycles where the `tick` clock-enable input is high, so an external prescaler can set the count rate. A registered one-cycle flag reports each wrap of each half.

Period and compare values are sampled into shadow copies. A write made while the counter runs therefore changes nothing until that half next wraps, and no PWM cycle is ever cut short or stretched. Pulling `en` low parks the block: both counters return to zero, both pins and both flags go low, and the shadows follow the inputs so that a restart uses the current settings.

Top module: `dual_pwm_timer`

## Requirements
- R1: With mode = 0, each half counts from 0 up to its own period value P and then wraps to 0. Each half's pin inverts at every wrap, so a pin changes level once every P+1 ticks, and each half keeps its own timing independently of the other.
- R2: With mode = 1, each half is a PWM generator. The pin is high for exactly min(C, P+1) of every P+1 ticks, where C is the compare value and P the period. C = 0 keeps the pin low, and C > P keeps it high.
- R3: With mode = 2, the halves form a 16-bit counter. The high-half pin inverts once every (PH+1)*(PL+1) ticks, and the low-half pin inverts once every PL+1 ticks.
- R4: With mode = 3, the high-half pin behaves as in R3, while the low-half pin carries the PWM waveform of R2 built from the low byte.
- R5: In modes 2 and 3, the upper counter advances only on a tick at which the lower counter wraps.
- R6: A period or compare value changed in the middle of a count cycle has no effect on that cycle. The new value governs the cycle that starts at the next wrap of that half.
- R7: `match_lo` and `match_hi` each rise for exactly one clock, once per wrap of their half. The flag appears in the same cycle as the pin change caused by that wrap.
- R8: While `tick` is low, neither counter advances, so tick-gated timing stretches in proportion.
- R9: When `en` is low, the counters hold at zero and both pins and both flags read low from the next clock. After `en` is raised again, the first low-half wrap happens on the (P+1)-th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low parks the block at zero |
| tick | input | 1 | Count enable for both counters |
| mode | input | 2 | 0 dual toggle, 1 dual PWM, 2 wide toggle, 3 wide toggle with low-byte PWM |
| lo_period | input | 8 | Low-half period value |
| lo_compare | input | 8 | Low-half PWM compare value |
| hi_period | input | 8 | High-half period value |
| hi_compare | input | 8 | High-half PWM compare value |
| out_lo | output | 1 | Low-half output pin |
| out_hi | output | 1 | High-half output pin |
| match_lo | output | 1 | Low-half wrap flag |
| match_hi | output | 1 | High-half wrap flag |

## Verification
Toggle mode is driven with different periods on the two halves. Distinct spacing between pin changes shows that the halves run independently, and the same pattern under a stretched `tick` shows that the count is gated.

PWM runs with compare values of zero, mid-range and above the period, which separates the clamping edge cases from normal duty. Cascaded runs measure the wide-period spacing, which is only right if the upper byte advances solely on lower wraps.

A change to period and compare made just after a wrap must show its old length and duty for one more window. A restart after a disable must produce its first wrap exactly on the expected tick, which shows that both counters were cleared.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL_TOGGLE = 2'd0,
    MODE_DUAL_PWM    = 2'd1,
    MODE_WIDE_TOGGLE = 2'd2,
    MODE_WIDE_PWM    = 2'd3
  } dpt_mode_e;

  function automatic logic is_cascaded(input dpt_mode_e m);
    return (m == MODE_WIDE_TOGGLE) || (m == MODE_WIDE_PWM);
  endfunction
endpackage

// File: rtl/dpt_half_counter.sv
module dpt_half_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         step,
  input  logic [W-1:0] period_in,
  input  logic [W-1:0] compare_in,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cmp_s,
  output logic         wrap
);
  logic [W-1:0] per_s;

  assign wrap = en && step && (cnt == per_s);

  // Shadow copies reload only at a wrap, or continuously while parked.
  always_ff @(posedge clk) begin
    if (rst) begin
      per_s <= '0;
      cmp_s <= '0;
    end else if (!en || wrap) begin
      per_s <= period_in;
      cmp_s <= compare_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (step)  cnt <= wrap ? '0 : cnt + 1'b1;
  end

  // R2 / R6: the count never passes the period that is currently in force
  a_r6_cnt_within_period: assert property (@(posedge clk) disable iff (rst)
    cnt <= per_s);

  // R9: a parked counter reads zero one clock later
  a_r9_parked_zero: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == '0);
endmodule

// File: rtl/dpt_out_stage.sv
module dpt_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         pwm_sel,
  input  logic         toggle_ev,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_s,
  output logic         pin,
  output logic         flag
);
  always_ff @(posedge clk) begin
    if (rst || !en)     pin <= 1'b0;
    else if (pwm_sel)   pin <= (cnt < cmp_s);
    else if (toggle_ev) pin <= ~pin;
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= en && toggle_ev;
  end

  // R1: in toggle role every wrap inverts the pin
  a_r1_wrap_inverts: assert property (@(posedge clk) disable iff (rst)
    (en && !pwm_sel && toggle_ev) |=> pin != $past(pin));

  // R2: zero compare value keeps a PWM pin low
  a_r2_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
    (en && pwm_sel && cmp_s == '0) |=> !pin);

  // R7: flag pulse follows each wrap
  a_r7_flag_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && toggle_ev) |=> flag);

  // R9: disabled block drives pin and flag low
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pin && !flag));
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [W-1:0] lo_period,
  input  logic [W-1:0] lo_compare,
  input  logic [W-1:0] hi_period,
  input  logic [W-1:0] hi_compare,
  output logic         out_lo,
  output logic         out_hi,
  output logic         match_lo,
  output logic         match_hi
);
  import dpt_pkg::*;

  localparam int NHALF = 2;

  dpt_mode_e    mode_e;
  logic         cascade;
  logic         lo_wrap, hi_wrap, hi_step;
  logic [W-1:0] lo_cnt, hi_cnt, lo_cmp_s, hi_cmp_s;

  assign mode_e  = dpt_mode_e'(mode);
  assign cascade = is_cascaded(mode_e);
  assign hi_step = cascade ? lo_wrap : tick;

  dpt_half_counter #(.W(W)) lo_ctr_i (
    .clk(clk), .rst(rst), .en(en), .step(tick),
    .period_in(lo_period), .compare_in(lo_compare),
    .cnt(lo_cnt), .cmp_s(lo_cmp_s), .wrap(lo_wrap)
  );

  dpt_half_counter #(.W(W)) hi_ctr_i (
    .clk(clk), .rst(rst), .en(en), .step(hi_step),
    .period_in(hi_period), .compare_in(hi_compare),
    .cnt(hi_cnt), .cmp_s(hi_cmp_s), .wrap(hi_wrap)
  );

  logic [NHALF-1:0]        sel_pwm, ev, pins, flags;
  logic [NHALF-1:0][W-1:0] cnts, cmps;

  assign sel_pwm[0] = (mode_e == MODE_DUAL_PWM) || (mode_e == MODE_WIDE_PWM);
  assign sel_pwm[1] = (mode_e == MODE_DUAL_PWM);
  assign ev         = {hi_wrap, lo_wrap};
  assign cnts       = {hi_cnt, lo_cnt};
  assign cmps       = {hi_cmp_s, lo_cmp_s};

  for (genvar g = 0; g < NHALF; g++) begin : g_out
    dpt_out_stage #(.W(W)) stage_i (
      .clk(clk), .rst(rst), .en(en),
      .pwm_sel(sel_pwm[g]), .toggle_ev(ev[g]),
      .cnt(cnts[g]), .cmp_s(cmps[g]),
      .pin(pins[g]), .flag(flags[g])
    );
  end

  assign out_lo   = pins[0];
  assign out_hi   = pins[1];
  assign match_lo = flags[0];
  assign match_hi = flags[1];

  // R5: cascaded upper byte holds unless the lower byte wraps
  a_r5_upper_waits: assert property (@(posedge clk) disable iff (rst)
    (!rst && en && cascade && !lo_wrap) |=> $stable(hi_cnt));

  // R3: a 16-bit wrap always coincides with a lower wrap
  a_r3_wide_wrap_aligned: assert property (@(posedge clk) disable iff (rst)
    (en && cascade && hi_wrap) |=> (match_lo && match_hi));
endmodule

// File: tb/dual_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module dual_pwm_timer_tb_top;
  logic clk = 1'b0, rst = 1'b1, en = 1'b0, tick = 1'b1, tick_half = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] lo_period = '0, lo_compare = '0, hi_period = '0, hi_compare = '0;
  logic out_lo, out_hi, match_lo, match_hi;
  int n_checks = 0, n_fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(negedge clk) tick <= tick_half ? ~tick : 1'b1;

  dual_pwm_timer #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .mode(mode),
    .lo_period(lo_period), .lo_compare(lo_compare),
    .hi_period(hi_period), .hi_compare(hi_compare),
    .out_lo(out_lo), .out_hi(out_hi), .match_lo(match_lo), .match_hi(match_hi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input int m, input int lp, input int lc, input int hp, input int hc);
    @(negedge clk);
    en = 1'b0; mode = 2'(m);
    lo_period = 8'(lp); lo_compare = 8'(lc); hi_period = 8'(hp); hi_compare = 8'(hc);
    @(negedge clk);
    en = 1'b1;
  endtask

  function automatic logic pin_of(input int sel);
    return sel == 0 ? out_lo : out_hi;
  endfunction

  function automatic logic flag_of(input int sel);
    return sel == 0 ? match_lo : match_hi;
  endfunction

  task automatic gap(input int sel, output int n);
    logic prev;
    int guard = 0;
    n = -1;
    prev = pin_of(sel);
    do begin @(negedge clk); guard++; end while (pin_of(sel) == prev && guard < 5000);
    prev = pin_of(sel);
    n = 0;
    do begin @(negedge clk); n++; end while (pin_of(sel) == prev && n < 5000);
  endtask

  task automatic sync(input int sel);
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!flag_of(sel) && guard < 5000);
  endtask

  // call right after a flag sample; counts samples and highs up to the next flag
  task automatic window(input int sel, output int len, output int highs);
    len = 0; highs = 0;
    do begin
      @(negedge clk);
      len++;
      highs += int'(pin_of(sel));
    end while (!flag_of(sel) && len < 5000);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_lo && !out_hi && !match_lo && !match_hi, "R9 reset quiet",
          int'({out_lo, out_hi, match_lo, match_hi}), 0);
    rst = 1'b0;
  endtask

  task automatic t_dual_toggle;
    int g;
    start(0, 4, 0, 6, 0);
    gap(0, g); check(g == 5, "R1 low gap", g, 5);
    gap(1, g); check(g == 7, "R1 high gap", g, 7);
  endtask

  task automatic t_restart;
    start(0, 5, 0, 9, 0);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 5) check(!out_lo, "R9 no wrap before tick P+1", int'(out_lo), 0);
      if (k == 6) begin
        check(out_lo, "R9 first wrap on tick P+1", int'(out_lo), 1);
        check(match_lo, "R7 flag with first wrap", int'(match_lo), 1);
      end
    end
  endtask

  task automatic t_flags;
    int pulses = 0, doubles = 0;
    logic prev = 1'b0;
    start(0, 3, 0, 3, 0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      pulses += int'(match_lo);
      if (prev && match_lo) doubles++;
      prev = match_lo;
    end
    check(pulses == 10, "R7 flag count", pulses, 10);
    check(doubles == 0, "R7 single-cycle flag", doubles, 0);
  endtask

  task automatic t_pwm(input int c, input int exp);
    int len, highs;
    start(1, 9, c, 5, 2);
    sync(0);
    window(0, len, highs);
    check(len == 10, "R2 low pwm period", len, 10);
    check(highs == exp, "R2 low pwm duty", highs, exp);
    sync(1);
    window(1, len, highs);
    check(len == 6 && highs == 2, "R2 high pwm duty", highs, 2);
  endtask

  task automatic t_shadow;
    int len, highs;
    start(1, 9, 3, 5, 1);
    sync(0);
    lo_period = 8'd4; lo_compare = 8'd2;
    window(0, len, highs);
    check(len == 10, "R6 old period kept", len, 10);
    check(highs == 3, "R6 old compare kept", highs, 3);
    window(0, len, highs);
    check(len == 5, "R6 new period at wrap", len, 5);
    check(highs == 2, "R6 new compare at wrap", highs, 2);
  endtask

  task automatic t_wide_toggle;
    int g;
    start(2, 3, 0, 4, 0);
    gap(1, g); check(g == 20, "R3 R5 wide gap", g, 20);
    gap(0, g); check(g == 4, "R3 low byte gap", g, 4);
  endtask

  task automatic t_wide_pwm;
    int g, len, highs;
    start(3, 4, 2, 2, 0);
    gap(1, g); check(g == 15, "R4 wide gap", g, 15);
    sync(0);
    window(0, len, highs);
    check(len == 5 && highs == 2, "R4 low byte pwm duty", highs, 2);
  endtask

  task automatic t_tick_gate;
    int g;
    tick_half = 1'b1;
    start(0, 4, 0, 4, 0);
    gap(0, g); check(g == 10, "R8 gated gap", g, 10);
    tick_half = 1'b0;
  endtask

  task automatic t_disable;
    start(1, 3, 4, 3, 4);
    repeat (6) @(negedge clk);
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!out_lo && !out_hi && !match_lo && !match_hi, "R9 parked quiet",
            int'({out_lo, out_hi, match_lo, match_hi}), 0);
    end
  endtask

  initial begin
    t_reset();
    t_dual_toggle();
    t_restart();
    t_flags();
    t_pwm(0, 0);
    t_pwm(3, 3);
    t_pwm(12, 10);
    t_shadow();
    t_wide_toggle();
    t_wide_pwm();
    t_tick_gate();
    t_disable();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule